// File: doc/BRIEF.md
# Memory-mapped countdown timer

This block is a 32-bit countdown timer that software controls through four word-wide registers on a small bus. Once it is both powered and enabled, it subtracts a programmable step from its count on every clock. When the remaining count can no longer absorb a full step, the timer expires. Expiry raises a sticky flag in the control word and a one-cycle interrupt pulse. The timer then either reloads from the period register and keeps running, or parks at zero until it is switched off and on again.

The bus carries a select, a write enable, a byte address, per-byte enables and write data. Every access gets a registered response one cycle later. That response holds the read data and a two-bit status that rejects partial-word accesses and unmapped offsets.

Top module: `ctmr_top`

## Requirements
- R1: After reset, all four registers read as 0 and `irq_o` is low.
- R2: The timer runs only while control bit 0 (power) and control bit 1 (enable) are both 1. If either bit is 0, the count holds its value.
- R3: The step is the low 8 bits of the scale register plus one. The upper scale bits are stored and read back, but they do not change the step.
- R4: While running, the count drops by the step on each clock. A count c > 0 expires on clock ceil(c/step) after the timer starts. A count of 0 expires on the first clock.
- R5: On the clock edge of expiry, control bit 3 (the flag) becomes 1 and `irq_o` goes high for exactly one cycle.
- R6: If control bit 2 (auto-reload) is 1 at expiry, the count takes the period value and counting continues. If it is 0, the count becomes 0 and no further expiry occurs until power or enable drops and then returns.
- R7: A legal write to the period register also writes the same value into the count.
- R8: The count can be written at any time, including while the timer runs. A write wins over that cycle's decrement.
- R9: A control write stores the whole written word. The flag takes the written bit 3, so writing 0 clears it and writing 1 sets it.
- R10: A scale change while running applies to the remaining count, and the steps already taken are kept.
- R11: The response status is 1 when any byte enable is 0. Otherwise it is 2 when the offset is not one of the four words, and 0 when the access is legal. The byte-enable check takes priority, and rejected writes change nothing.
- R12: The registers are at byte offsets 0x0 (control), 0x4 (period), 0x8 (scale) and 0xC (count). `rsp_valid` and the read data appear in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte offset |
| bus_be | input | DW/8 (4) | Byte enables |
| bus_wdata | input | DW (32) | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | DW (32) | Read data (0 for writes and errors) |
| rsp_err | output | 2 | 0 ok, 1 partial width, 2 unmapped |
| irq_o | output | 1 | One-cycle expiry pulse |

## Verification
The bench uses the default parameters: a 32-bit data path, an 8-bit address and an 8-bit scale field. Because the address is 8 bits wide, offsets above the four words (0x14, 0x40) and unaligned offsets can be decoded, so both error codes and their priority can be reached. With the 8-bit scale field, a scale word with its upper bits set still yields a small step, which shows those bits are ignored. Counts are kept small so that ceiling expiry times, reloads, mid-run count writes and mid-run scale changes can be measured edge by edge at the interrupt pin.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    // byte offsets of the register words
    localparam int OFS_CTRL   = 0;
    localparam int OFS_PERIOD = 4;
    localparam int OFS_SCALE  = 8;
    localparam int OFS_COUNT  = 12;
    localparam int NREG       = 4;

    // control word bit positions
    localparam int CB_PWR  = 0;
    localparam int CB_EN   = 1;
    localparam int CB_ARLD = 2;
    localparam int CB_FLAG = 3;

    typedef enum logic [1:0] {
        RSP_OK     = 2'd0,
        RSP_SIZE   = 2'd1,
        RSP_DECODE = 2'd2
    } rsp_e;

    typedef enum logic [1:0] {
        IDX_CTRL   = 2'd0,
        IDX_PERIOD = 2'd1,
        IDX_SCALE  = 2'd2,
        IDX_COUNT  = 2'd3
    } reg_e;

    typedef struct packed {
        logic ctrl;
        logic period;
        logic scale;
        logic count;
    } wstb_t;

    // width violations outrank decode misses
    function automatic rsp_e classify(input logic full_word, input logic mapped);
        if (!full_word)
            return RSP_SIZE;
        else if (!mapped)
            return RSP_DECODE;
        else
            return RSP_OK;
    endfunction

endpackage

// File: rtl/ctmr_bus_if.sv
module ctmr_bus_if
    import ctmr_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] be,
    input  logic [DW-1:0] rd_ctrl,
    input  logic [DW-1:0] rd_period,
    input  logic [DW-1:0] rd_scale,
    input  logic [DW-1:0] rd_count,
    output wstb_t         wstb,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [1:0]    rsp_err
);
    localparam int LSB = $clog2(BW);

    logic          full_word;
    logic          mapped;
    logic [1:0]    idx;
    rsp_e          cls;
    logic [NREG-1:0] hit;
    logic [DW-1:0] rd_arr [NREG];
    logic [DW-1:0] rd_sel;

    assign full_word = &be;
    assign mapped    = (addr[LSB-1:0] == '0) && ((addr >> (LSB + 2)) == '0);
    assign idx       = addr[LSB+1:LSB];
    assign cls       = classify(full_word, mapped);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_hit
            assign hit[g] = sel & we & (cls == RSP_OK) & (idx == 2'(g));
        end
    endgenerate

    assign wstb.ctrl   = hit[IDX_CTRL];
    assign wstb.period = hit[IDX_PERIOD];
    assign wstb.scale  = hit[IDX_SCALE];
    assign wstb.count  = hit[IDX_COUNT];

    assign rd_arr[IDX_CTRL]   = rd_ctrl;
    assign rd_arr[IDX_PERIOD] = rd_period;
    assign rd_arr[IDX_SCALE]  = rd_scale;
    assign rd_arr[IDX_COUNT]  = rd_count;
    assign rd_sel = rd_arr[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= RSP_OK;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= sel;
            rsp_err   <= sel ? cls : RSP_OK;
            rsp_rdata <= (sel && !we && cls == RSP_OK) ? rd_sel : '0;
        end
    end
endmodule

// File: rtl/ctmr_regfile.sv
module ctmr_regfile
    import ctmr_pkg::*;
#(
    parameter int DW = 32,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  wstb_t         wstb,
    input  logic [DW-1:0] wdata,
    input  logic          expire,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] period_q,
    output logic [DW-1:0] scale_q,
    output logic          active,
    output logic          arld,
    output logic [DW-1:0] step
);
    logic [DW-1:0] ctrl_nxt;

    // written word first, then expiry forces the flag on
    always_comb begin
        ctrl_nxt = wstb.ctrl ? wdata : ctrl_q;
        if (expire)
            ctrl_nxt[CB_FLAG] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '0;
            scale_q  <= '0;
        end else begin
            ctrl_q <= ctrl_nxt;
            if (wstb.period)
                period_q <= wdata;
            if (wstb.scale)
                scale_q <= wdata;
        end
    end

    assign active = ctrl_q[CB_PWR] & ctrl_q[CB_EN];
    assign arld   = ctrl_q[CB_ARLD];
    assign step   = DW'(scale_q[SW-1:0]) + DW'(1);
endmodule

// File: rtl/ctmr_count_core.sv
module ctmr_count_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          arld,
    input  logic [DW-1:0] step,
    input  logic [DW-1:0] period_q,
    input  logic          cnt_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt_q,
    output logic          halt_q,
    output logic          expire,
    output logic          irq_o
);
    logic run;

    assign run    = active & ~halt_q;
    assign expire = run & (cnt_q <= step);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            halt_q <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            irq_o <= expire;
            if (cnt_wr)
                cnt_q <= wdata;
            else if (expire)
                cnt_q <= arld ? period_q : '0;
            else if (run)
                cnt_q <= cnt_q - step;

            if (!active)
                halt_q <= 1'b0;
            else if (expire && !arld)
                halt_q <= 1'b1;
        end
    end
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int SW = 8,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_be,
    input  logic [DW-1:0] bus_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [1:0]    rsp_err,
    output logic          irq_o
);
    wstb_t         wstb;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] period_q;
    logic [DW-1:0] scale_q;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] step;
    logic          active;
    logic          arld;
    logic          expire;
    logic          halt_q;
    logic          cnt_wr;
    logic          wr_period;
    logic          flag_bit;

    assign cnt_wr    = wstb.period | wstb.count;
    assign wr_period = wstb.period;
    assign flag_bit  = ctrl_q[CB_FLAG];

    ctmr_bus_if #(.AW(AW), .DW(DW)) bus_i (
        .clk       (clk),
        .rst       (rst),
        .sel       (bus_sel),
        .we        (bus_we),
        .addr      (bus_addr),
        .be        (bus_be),
        .rd_ctrl   (ctrl_q),
        .rd_period (period_q),
        .rd_scale  (scale_q),
        .rd_count  (cnt_q),
        .wstb      (wstb),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    ctmr_regfile #(.DW(DW), .SW(SW)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wstb     (wstb),
        .wdata    (bus_wdata),
        .expire   (expire),
        .ctrl_q   (ctrl_q),
        .period_q (period_q),
        .scale_q  (scale_q),
        .active   (active),
        .arld     (arld),
        .step     (step)
    );

    ctmr_count_core #(.DW(DW)) core_i (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .arld     (arld),
        .step     (step),
        .period_q (period_q),
        .cnt_wr   (cnt_wr),
        .wdata    (bus_wdata),
        .cnt_q    (cnt_q),
        .halt_q   (halt_q),
        .expire   (expire),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [BW-1:0] bus_be,
    input logic          rsp_valid,
    input logic [1:0]    rsp_err,
    input logic          irq_o,
    input logic          flag_bit,
    input logic          active,
    input logic          arld,
    input logic          halt_q,
    input logic          expire,
    input logic          cnt_wr,
    input logic          wr_period,
    input logic [DW-1:0] cnt_q,
    input logic [DW-1:0] period_q,
    input logic [DW-1:0] step
);
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag_bit); // R5
    AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(expire)); // R5
    AST_SIZE_OUTRANKS: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_be != '1) |=> (rsp_valid && rsp_err == 2'd1)); // R11
    AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_be != '1) |=> $stable(period_q)); // R11
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!active && !cnt_wr) |=> $stable(cnt_q)); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (active && !halt_q && !expire && !cnt_wr)
        |=> (cnt_q == $past(cnt_q) - $past(step))); // R4
    AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (expire && !arld && !cnt_wr) |=> (cnt_q == '0)); // R6
    AST_RELOAD_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (expire && arld && !cnt_wr) |=> (cnt_q == $past(period_q))); // R6
    AST_PERIOD_MIRROR: assert property (@(posedge clk) disable iff (rst)
        wr_period |=> (cnt_q == period_q)); // R7
endmodule

bind ctmr_top ctmr_chk #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .irq_o     (irq_o),
    .flag_bit  (flag_bit),
    .active    (active),
    .arld      (arld),
    .halt_q    (halt_q),
    .expire    (expire),
    .cnt_wr    (cnt_wr),
    .wr_period (wr_period),
    .cnt_q     (cnt_q),
    .period_q  (period_q),
    .step      (step)
);

// File: tb/ctmr_top_tb_top.sv
module ctmr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_err;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0]  err;
        logic        chk_data;
        logic [31:0] data;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    ctmr_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .irq_o     (irq_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R12", "unexpected response", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(rsp_err == it.err, it.req, "status", rsp_err, it.err);
                if (it.chk_data)
                    check(rsp_rdata == it.data, it.req, "read data", rsp_rdata, it.data);
            end
        end
    end

    // driver: starts and ends at a falling edge
    task automatic access(input bit we, input logic [7:0] a, input logic [3:0] be,
                          input logic [31:0] d, input logic [1:0] exp_err,
                          input logic [31:0] exp_d, input string req);
        item_t it;
        it.err = exp_err;
        it.chk_data = !we && exp_err == 2'd0;
        it.data = exp_d;
        it.req = req;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        access(1'b1, a, 4'hF, d, 2'd0, '0, req);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp_d, input string req);
        access(1'b0, a, 4'hF, '0, 2'd0, exp_d, req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // edges from the last access until irq_o is seen high
    task automatic wait_irq(input int exp_n, input string req);
        int n = 0;
        bit seen = 1'b0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (irq_o) seen = 1'b1;
        end
        check(seen && n == exp_n, req, "edges to expiry", n, exp_n);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(irq_o == 1'b0, "R1", "irq after reset", irq_o, 0);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        rd(8'h0, 32'h0, "R1");
        rd(8'h4, 32'h0, "R1");
        rd(8'h8, 32'h0, "R1");
        rd(8'hC, 32'h0, "R1");

        // R12 map, R7 period mirrors into count, R9 whole word stored
        wr(8'h0, 32'hA5A5_0000, "R9");
        rd(8'h0, 32'hA5A5_0000, "R9");
        wr(8'h0, 32'h0, "R9");
        wr(8'h4, 32'h0000_1234, "R7");
        rd(8'h4, 32'h0000_1234, "R12");
        rd(8'hC, 32'h0000_1234, "R7");

        // R11 status codes and priority, rejected writes inert
        access(1'b0, 8'h40, 4'h3, '0, 2'd1, '0, "R11");
        access(1'b0, 8'h40, 4'hF, '0, 2'd2, '0, "R11");
        access(1'b0, 8'h02, 4'hF, '0, 2'd2, '0, "R11");
        access(1'b1, 8'h04, 4'h7, 32'h77, 2'd1, '0, "R11");
        access(1'b1, 8'h14, 4'hF, 32'h55, 2'd2, '0, "R11");
        rd(8'h4, 32'h0000_1234, "R11");

        // R3 upper scale bits kept but ignored, R4 ceiling expiry, R5, R6 one-shot
        wr(8'h4, 32'd10, "R4");
        wr(8'h8, 32'hFFFF_FF02, "R3");
        rd(8'h8, 32'hFFFF_FF02, "R3");
        wr(8'h0, 32'h3, "R4");
        wait_irq(4, "R4");
        idle(1);
        check(irq_o == 1'b0, "R5", "irq pulse width", irq_o, 0);
        rd(8'h0, 32'hB, "R5");
        rd(8'hC, 32'h0, "R6");
        begin
            bit any = 1'b0;
            for (int i = 0; i < 6; i++) begin
                idle(1);
                if (irq_o) any = 1'b1;
            end
            check(!any, "R6", "no expiry while parked", any, 0);
        end
        // R6 restart after power/enable drop; R4 zero count expires at once
        wr(8'h0, 32'h0, "R6");
        wr(8'h0, 32'h3, "R6");
        wait_irq(1, "R6");
        wr(8'h0, 32'h0, "R9");

        // R9 flag follows the written bit
        rd(8'h0, 32'h0, "R9");
        wr(8'h0, 32'h8, "R9");
        rd(8'h0, 32'h8, "R9");
        wr(8'h0, 32'h0, "R9");
        rd(8'h0, 32'h0, "R9");

        // R2 count frozen when either control bit is low
        wr(8'h4, 32'd50, "R2");
        wr(8'h8, 32'h0, "R2");
        wr(8'h0, 32'h3, "R2");
        wr(8'h0, 32'h1, "R2");
        idle(5);
        rd(8'hC, 32'd49, "R2");
        wr(8'h0, 32'h2, "R2");
        idle(4);
        rd(8'hC, 32'd49, "R2");
        wr(8'h0, 32'h0, "R2");

        // R6 auto-reload period
        wr(8'h4, 32'd5, "R6");
        wr(8'h0, 32'h7, "R6");
        wait_irq(5, "R6");
        wait_irq(5, "R6");
        wr(8'h0, 32'h0, "R6");

        // R8 count write while running
        wr(8'h4, 32'd100, "R8");
        wr(8'h0, 32'h3, "R8");
        wr(8'hC, 32'd4, "R8");
        wait_irq(4, "R8");
        wr(8'h0, 32'h0, "R8");

        // R10 scale change mid-run keeps progress
        wr(8'h4, 32'd100, "R10");
        wr(8'h0, 32'h3, "R10");
        wr(8'h8, 32'd9, "R10");
        wait_irq(10, "R10");
        wr(8'h0, 32'h0, "R10");

        idle(2);
        check(sb_q.size() == 0, "R12", "responses outstanding", sb_q.size(), 0);
        done = 1'b1;
        report();
    end
endmodule